// File: doc/BRIEF.md
# Power-Down Entry and Wake-Up Controller

This block decides when a small 8-bit microcontroller core stops its system clock and how it comes back. A halt strobe from the instruction decoder is the only way in. On entry the block turns the system clock gate off and sets the power-down status flag. It clears the time-out status flag and sends a clear pulse to the watchdog. The watchdog keeps running only when its clock comes from its own oscillator. The whole block runs on an always-on low-speed clock, so it keeps watching for wake sources while the system clock is stopped.

While halted, the block arbitrates between four wake sources in a fixed order. From highest to lowest they are an external reset, a watchdog overflow, a pending interrupt, and a falling edge on an enabled Port A pin. When a source wins, the block turns the clock gate on again. One cycle later it issues a one-cycle resume pulse that carries a 2-bit action code. The core uses that code to continue, take the interrupt, apply a watchdog reset or apply a full reset. Firmware can tell why the core woke by reading the two status flags.

Top module: `pwrdn_wake_ctrl`

## Requirements
- R1: After reset, or a cycle with `por_i` high, `sys_clk_en_o`=1, `pdf_o`=0, `to_o`=0, `resume_vld_o`=0 and `wdt_run_o`=1.
- R2: A `halt_stb_i` sampled while running causes, at the next edge, `sys_clk_en_o`=0, `pdf_o`=1 and `to_o`=0, together with a `wdt_clr_o` pulse exactly one cycle long.
- R3: While the clock gate is off, `wdt_run_o` equals the inverse of `wdt_clk_is_sys_i`. While the gate is on, `wdt_run_o`=1.
- R4: A `clrwdt_stb_i` clears `pdf_o` at the next edge and pulses `wdt_clr_o`. A `por_i` cycle clears both `pdf_o` and `to_o`.
- R5: An `ext_rst_i` sampled while halted turns the gate on at the next edge and yields resume code 2'b11 (full reset).
- R6: A `wdt_ovf_i` that wins while halted yields resume code 2'b10 (watchdog reset), sets `to_o` and leaves `pdf_o` at 1.
- R7: A pending `irq_req_i` that wins while halted yields code 2'b01 (take interrupt) if `irq_en_i`=1 and `stack_full_i`=0. Otherwise it yields code 2'b00 (continue at the next instruction).
- R8: A high-to-low transition on a Port A pin whose bit in `pa_wake_en_i` is 1 wakes the core with code 2'b00. The transition passes a two-flop synchronizer, so the gate turns on at the third edge after the pin changes. A transition on a pin whose enable bit is 0 leaves the gate off.
- R9: When several sources arrive in the same cycle, the order is external reset, then watchdog overflow, then interrupt, then Port A edge.
- R10: `resume_vld_o` is high for exactly one cycle, one cycle after `sys_clk_en_o` rises. Wake inputs sampled while running produce no resume pulse.
- R11: A `wdt_ovf_i` in any state sets `to_o` unless a halt entry or `por_i` happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-speed clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_i | input | 1 | Power-up indication, synchronous |
| halt_stb_i | input | 1 | Halt instruction executed |
| clrwdt_stb_i | input | 1 | Clear-watchdog instruction executed |
| ext_rst_i | input | 1 | External reset request |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| wdt_clk_is_sys_i | input | 1 | 1: watchdog clocked from the system clock |
| pa_pin_i | input | 8 | Port A pin levels, asynchronous |
| pa_wake_en_i | input | 8 | Per-pin falling-edge wake enable |
| irq_req_i | input | 1 | Interrupt request pending |
| irq_en_i | input | 1 | Interrupt enabled |
| stack_full_i | input | 1 | Return stack has no free level |
| sys_clk_en_o | output | 1 | System clock gate enable |
| pdf_o | output | 1 | Power-down status flag |
| to_o | output | 1 | Watchdog time-out status flag |
| resume_vld_o | output | 1 | One-cycle resume pulse |
| resume_code_o | output | 2 | 00 next, 01 interrupt, 10 watchdog reset, 11 full reset |
| wdt_clr_o | output | 1 | Watchdog clear pulse |
| wdt_run_o | output | 1 | Watchdog counting enable |

## Verification
A direct wake input sampled at edge k turns the gate on at edge k, and the resume pulse follows at edge k+1. A Port A edge takes two more edges to get through the synchronizer. The bench therefore drops a pin two cycles before it pulses the direct sources, so that all of them reach the arbiter at the same edge. The bench drives inputs on falling clock edges and reads outputs on the next falling edge. It checks the gate one half-cycle after the winning edge and the code one cycle later. It sweeps all sixteen combinations of the four sources against all four combinations of interrupt enable and stack full, and works out each expected code from the priority order.

// File: rtl/pwrdn_pkg.sv
// Package: shared encodings for the power-down controller.
// Assumes: resume codes are decoded by the core's sequencer as listed.
package pwrdn_pkg;

    typedef enum logic [1:0] {
        RES_NEXT = 2'b00,
        RES_IRQ  = 2'b01,
        RES_WDT  = 2'b10,
        RES_FULL = 2'b11
    } resume_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'b00,
        ST_HALT = 2'b01,
        ST_WAKE = 2'b10
    } pstate_e;

endpackage

// File: rtl/pwrdn_pa_edge.sv
// Module: per-pin synchronizer and falling-edge detector for Port A.
// Assumes: pins are asynchronous; clk is the always-on clock; pins idle high.
// Flops reset low, so a pin held low through reset gives no edge.
module pwrdn_pa_edge #(
    parameter int PA_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PA_W-1:0] pin_i,
    input  logic [PA_W-1:0] wake_en_i,
    output logic            fall_any_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [PA_W-1:0] fall_vec;

    for (genvar gi = 0; gi < PA_W; gi++) begin : g_pin
        logic [SYNC_STAGES-1:0] sync_q;
        logic                   prev_q;

        // Shift the raw pin level through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_q <= '0;
            end else begin
                sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i[gi]};
            end
        end

        // Hold the previous synchronized level for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
            end else begin
                prev_q <= sync_q[LAST];
            end
        end

        assign fall_vec[gi] = prev_q & ~sync_q[LAST] & wake_en_i[gi];
    end

    assign fall_any_o = |fall_vec;

endmodule

// File: rtl/pwrdn_wake_arb.sv
// Module: fixed-priority wake source arbiter.
// Assumes: all inputs are synchronous to clk. Order: ext reset, watchdog,
// interrupt, Port A edge. Purely combinational.
module pwrdn_wake_arb
    import pwrdn_pkg::*;
(
    input  logic    ext_rst_i,
    input  logic    wdt_ovf_i,
    input  logic    irq_req_i,
    input  logic    irq_en_i,
    input  logic    stack_full_i,
    input  logic    pa_fall_i,
    output logic    wake_vld_o,
    output resume_e wake_code_o
);
    // Select the winning source and its resume action.
    always_comb begin
        wake_vld_o  = 1'b1;
        wake_code_o = RES_NEXT;
        if (ext_rst_i) begin
            wake_code_o = RES_FULL;
        end else if (wdt_ovf_i) begin
            wake_code_o = RES_WDT;
        end else if (irq_req_i) begin
            wake_code_o = (irq_en_i && !stack_full_i) ? RES_IRQ : RES_NEXT;
        end else if (pa_fall_i) begin
            wake_code_o = RES_NEXT;
        end else begin
            wake_vld_o  = 1'b0;
        end
    end

endmodule

// File: rtl/pwrdn_fsm.sv
// Module: halt/wake state machine, status flags and watchdog controls.
// Assumes: wake_vld_i is only acted on while halted; por_i is synchronous.
module pwrdn_fsm
    import pwrdn_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    por_i,
    input  logic    halt_stb_i,
    input  logic    clrwdt_stb_i,
    input  logic    wdt_ovf_i,
    input  logic    wdt_clk_is_sys_i,
    input  logic    wake_vld_i,
    input  resume_e wake_code_i,
    output logic    sys_clk_en_o,
    output logic    pdf_o,
    output logic    to_o,
    output logic    resume_vld_o,
    output resume_e resume_code_o,
    output logic    wdt_clr_o,
    output logic    wdt_run_o
);
    pstate_e state_q, state_d;
    resume_e code_q;
    logic    pdf_q, to_q, clr_q, rvld_q;
    resume_e rcode_q;
    logic    enter_halt;

    assign enter_halt = (state_q == ST_RUN) && halt_stb_i;

    // Next-state selection for run / halt / wake.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN:  if (halt_stb_i) state_d = ST_HALT;
            ST_HALT: if (wake_vld_i) state_d = ST_WAKE;
            ST_WAKE: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // State register; power-up returns to run.
    always_ff @(posedge clk) begin
        if (!rst_n || por_i) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture the winning resume action at the wake edge.
    always_ff @(posedge clk) begin
        if (!rst_n || por_i) begin
            code_q <= RES_NEXT;
        end else if (state_q == ST_HALT && wake_vld_i) begin
            code_q <= wake_code_i;
        end
    end

    // Power-down flag: set on halt, cleared by power-up or clear-watchdog.
    always_ff @(posedge clk) begin
        if (!rst_n || por_i) begin
            pdf_q <= 1'b0;
        end else if (enter_halt) begin
            pdf_q <= 1'b1;
        end else if (clrwdt_stb_i) begin
            pdf_q <= 1'b0;
        end
    end

    // Time-out flag: cleared on halt, set by any watchdog overflow.
    always_ff @(posedge clk) begin
        if (!rst_n || por_i) begin
            to_q <= 1'b0;
        end else if (enter_halt) begin
            to_q <= 1'b0;
        end else if (wdt_ovf_i) begin
            to_q <= 1'b1;
        end
    end

    // Watchdog clear pulse on halt entry or clear-watchdog strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || por_i) begin
            clr_q <= 1'b0;
        end else begin
            clr_q <= enter_halt || clrwdt_stb_i;
        end
    end

    // Resume pulse one cycle after the gate reopens.
    always_ff @(posedge clk) begin
        if (!rst_n || por_i) begin
            rvld_q  <= 1'b0;
            rcode_q <= RES_NEXT;
        end else begin
            rvld_q  <= (state_q == ST_WAKE);
            rcode_q <= code_q;
        end
    end

    assign sys_clk_en_o  = (state_q != ST_HALT);
    assign wdt_run_o     = !((state_q == ST_HALT) && wdt_clk_is_sys_i);
    assign pdf_o         = pdf_q;
    assign to_o          = to_q;
    assign wdt_clr_o     = clr_q;
    assign resume_vld_o  = rvld_q;
    assign resume_code_o = rcode_q;

    // R2: halt entry gates the clock and sets/clears flags.
    a_r2_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_halt && !por_i) |=> (state_q == ST_HALT && pdf_q && !to_q && clr_q));

    // R10: resume pulse is a single cycle.
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rvld_q && !por_i) |=> !rvld_q);

    // R10: resume pulse only while the clock gate is open.
    a_r10_gate_open: assert property (@(posedge clk) disable iff (!rst_n)
        rvld_q |-> sys_clk_en_o);

    // R11: a watchdog overflow sets the time-out flag.
    a_r11_to_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_ovf_i && !por_i && !enter_halt) |=> to_q);

    // R4: clear-watchdog clears the power-down flag.
    a_r4_pdf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clrwdt_stb_i && !enter_halt) |=> !pdf_q);

endmodule

// File: rtl/pwrdn_wake_ctrl.sv
// Module: top of the power-down entry and wake-up controller.
// Assumes: clk is the always-on low-speed clock; rst_n is synchronous,
// active low. Instantiates the Port A edge detector, the arbiter and the FSM.
module pwrdn_wake_ctrl
    import pwrdn_pkg::*;
#(
    parameter int PA_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            por_i,
    input  logic            halt_stb_i,
    input  logic            clrwdt_stb_i,
    input  logic            ext_rst_i,
    input  logic            wdt_ovf_i,
    input  logic            wdt_clk_is_sys_i,
    input  logic [PA_W-1:0] pa_pin_i,
    input  logic [PA_W-1:0] pa_wake_en_i,
    input  logic            irq_req_i,
    input  logic            irq_en_i,
    input  logic            stack_full_i,
    output logic            sys_clk_en_o,
    output logic            pdf_o,
    output logic            to_o,
    output logic            resume_vld_o,
    output logic [1:0]      resume_code_o,
    output logic            wdt_clr_o,
    output logic            wdt_run_o
);
    logic    pa_fall;
    logic    wake_vld;
    resume_e wake_code;
    resume_e res_code;

    pwrdn_pa_edge #(
        .PA_W        (PA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_pa_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pa_pin_i),
        .wake_en_i  (pa_wake_en_i),
        .fall_any_o (pa_fall)
    );

    pwrdn_wake_arb u_arb (
        .ext_rst_i    (ext_rst_i),
        .wdt_ovf_i    (wdt_ovf_i),
        .irq_req_i    (irq_req_i),
        .irq_en_i     (irq_en_i),
        .stack_full_i (stack_full_i),
        .pa_fall_i    (pa_fall),
        .wake_vld_o   (wake_vld),
        .wake_code_o  (wake_code)
    );

    pwrdn_fsm u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .por_i            (por_i),
        .halt_stb_i       (halt_stb_i),
        .clrwdt_stb_i     (clrwdt_stb_i),
        .wdt_ovf_i        (wdt_ovf_i),
        .wdt_clk_is_sys_i (wdt_clk_is_sys_i),
        .wake_vld_i       (wake_vld),
        .wake_code_i      (wake_code),
        .sys_clk_en_o     (sys_clk_en_o),
        .pdf_o            (pdf_o),
        .to_o             (to_o),
        .resume_vld_o     (resume_vld_o),
        .resume_code_o    (res_code),
        .wdt_clr_o        (wdt_clr_o),
        .wdt_run_o        (wdt_run_o)
    );

    assign resume_code_o = res_code;

    // R3: watchdog stops while halted if it runs from the system clock.
    a_r3_wdt_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_clk_en_o && wdt_clk_is_sys_i) |-> !wdt_run_o);

    // R9: external reset always wins the arbitration.
    a_r9_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_i |-> (wake_vld && wake_code == RES_FULL));

    // R9: watchdog beats interrupt and Port A.
    a_r9_wdt_second: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_ovf_i && !ext_rst_i) |-> (wake_code == RES_WDT));

    // R5: external reset while halted reopens the gate at the next edge.
    a_r5_ext_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_clk_en_o && ext_rst_i && !por_i) |=> sys_clk_en_o);

    // R8: an enabled Port A edge alone continues at the next instruction.
    a_r8_pa_next: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_fall && !ext_rst_i && !wdt_ovf_i && !irq_req_i) |-> (wake_code == RES_NEXT));

endmodule

// File: tb/pwrdn_wake_ctrl_bench.sv
module pwrdn_wake_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_i = 1'b0, halt_stb_i = 1'b0, clrwdt_stb_i = 1'b0;
    logic       ext_rst_i = 1'b0, wdt_ovf_i = 1'b0, wdt_clk_is_sys_i = 1'b0;
    logic [7:0] pa_pin_i = 8'hFF, pa_wake_en_i = 8'h04;
    logic       irq_req_i = 1'b0, irq_en_i = 1'b0, stack_full_i = 1'b0;
    logic       sys_clk_en_o, pdf_o, to_o, resume_vld_o, wdt_clr_o, wdt_run_o;
    logic [1:0] resume_code_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrdn_wake_ctrl u_pwrdn_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .por_i(por_i), .halt_stb_i(halt_stb_i),
        .clrwdt_stb_i(clrwdt_stb_i), .ext_rst_i(ext_rst_i), .wdt_ovf_i(wdt_ovf_i),
        .wdt_clk_is_sys_i(wdt_clk_is_sys_i), .pa_pin_i(pa_pin_i),
        .pa_wake_en_i(pa_wake_en_i), .irq_req_i(irq_req_i), .irq_en_i(irq_en_i),
        .stack_full_i(stack_full_i), .sys_clk_en_o(sys_clk_en_o), .pdf_o(pdf_o),
        .to_o(to_o), .resume_vld_o(resume_vld_o), .resume_code_o(resume_code_o),
        .wdt_clr_o(wdt_clr_o), .wdt_run_o(wdt_run_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // R2/R3: enter halt and check the entry state.
    task automatic enter_halt();
        tick(); halt_stb_i = 1'b1;
        tick(); halt_stb_i = 1'b0;
        chk("R2 gate off", sys_clk_en_o, 0);
        chk("R2 pdf set", pdf_o, 1);
        chk("R2 to clear", to_o, 0);
        chk("R2 wdt clr", wdt_clr_o, 1);
        chk("R3 wdt run", wdt_run_o, !wdt_clk_is_sys_i);
        tick();
        chk("R2 clr one cycle", wdt_clr_o, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 gate", sys_clk_en_o, 1);
        chk("R1 pdf", pdf_o, 0);
        chk("R1 to", to_o, 0);
        chk("R1 resume", resume_vld_o, 0);
        chk("R1 wdt run", wdt_run_o, 1);

        // R11/R10: overflow and ext reset while running
        wdt_ovf_i = 1'b1; ext_rst_i = 1'b1; irq_req_i = 1'b1;
        tick(); wdt_ovf_i = 1'b0; ext_rst_i = 1'b0; irq_req_i = 1'b0;
        chk("R11 to set in run", to_o, 1);
        chk("R10 no resume in run", resume_vld_o, 0);
        tick();
        chk("R10 no resume in run 2", resume_vld_o, 0);
        chk("R10 gate stays on", sys_clk_en_o, 1);

        // R3 with watchdog on system clock
        wdt_clk_is_sys_i = 1'b1;
        enter_halt();
        ext_rst_i = 1'b1; tick(); ext_rst_i = 1'b0;
        chk("R5 gate on", sys_clk_en_o, 1);
        chk("R3 wdt run after wake", wdt_run_o, 1);
        tick();
        chk("R5 code full", resume_code_o, 3);
        chk("R10 pulse", resume_vld_o, 1);
        tick();
        chk("R10 pulse ends", resume_vld_o, 0);
        wdt_clk_is_sys_i = 1'b0;

        // R4 clear-watchdog clears pdf
        clrwdt_stb_i = 1'b1; tick(); clrwdt_stb_i = 1'b0;
        chk("R4 pdf cleared", pdf_o, 0);
        chk("R4 clr pulse", wdt_clr_o, 1);

        // R8 disabled pin ignored, enabled pin wakes with timing
        enter_halt();
        pa_pin_i[5] = 1'b0;
        repeat (4) tick();
        chk("R8 disabled pin ignored", sys_clk_en_o, 0);
        pa_pin_i[2] = 1'b0;
        tick(); tick();
        chk("R8 gate still off", sys_clk_en_o, 0);
        tick();
        chk("R8 gate on third edge", sys_clk_en_o, 1);
        tick();
        chk("R8 code next", resume_code_o, 0);
        chk("R8 pulse", resume_vld_o, 1);
        pa_pin_i = 8'hFF;
        repeat (3) tick();

        // R9/R5/R6/R7/R8 sweep of all source combinations
        for (int s = 0; s < 16; s++) begin
            for (int e = 0; e < 4; e++) begin
                int exp_code;
                bit any;
                any = (s != 0);
                if (s[3])      exp_code = 3;
                else if (s[2]) exp_code = 2;
                else if (s[1]) exp_code = (e[0] && !e[1]) ? 1 : 0;
                else           exp_code = 0;
                enter_halt();
                if (s[0]) pa_pin_i[2] = 1'b0;
                tick(); tick();
                ext_rst_i = s[3]; wdt_ovf_i = s[2]; irq_req_i = s[1];
                irq_en_i = e[0]; stack_full_i = e[1];
                tick();
                ext_rst_i = 1'b0; wdt_ovf_i = 1'b0; irq_req_i = 1'b0;
                if (any) begin
                    chk("R9 gate on", sys_clk_en_o, 1);
                    chk("R10 no early pulse", resume_vld_o, 0);
                    tick();
                    chk("R9 code", resume_code_o, exp_code);
                    chk("R10 pulse", resume_vld_o, 1);
                    chk("R6 to", to_o, s[2]);
                    chk("R6 pdf kept", pdf_o, 1);
                    tick();
                    chk("R10 pulse ends", resume_vld_o, 0);
                end else begin
                    chk("R9 no source no wake", sys_clk_en_o, 0);
                    ext_rst_i = 1'b1; tick(); ext_rst_i = 1'b0;
                    tick(); tick();
                end
                pa_pin_i = 8'hFF;
                repeat (3) tick();
            end
        end

        // R4/R1: power-up clears both flags
        wdt_ovf_i = 1'b1; tick(); wdt_ovf_i = 1'b0;
        enter_halt();
        por_i = 1'b1; tick(); por_i = 1'b0;
        chk("R4 por pdf", pdf_o, 0);
        chk("R4 por to", to_o, 0);
        chk("R1 por gate", sys_clk_en_o, 1);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule